// File: doc/BRIEF.md
# High-Voltage Erase and Program Mode Sequencer

This block holds the device-side mode logic of an electrically erasable byte memory. It samples the address strobe, the active-low output enable, a boolean qualifier that says the output-enable pin carries the programming voltage, and a second qualifier that says address line 9 carries the elevated identifier/erase voltage. From these it derives the current operating mode and fires one-cycle erase and program strobes toward a storage array, which is not part of this block. It also supplies the two identifier bytes.

Erase can be reached in two ways. The first is direct, through a fixed pattern on the address lines while both qualifiers are asserted. The second is a two-write unlock sequence in which each write must hold the strobe high for a minimum time. The pulse width is counted in ticks from a free-running microsecond tick input and judged when the strobe falls. Once an erase or program has been carried out, the block remains in a verify mode until a power-on reset. The address and data arrive already demultiplexed: the low address byte is captured outside this block.

Top module: `mode_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the outputs take these values after that edge: `mode`=1 (standby), `drive_en`=0, `id_byte`=0, `erase_pulse`=0, `prog_pulse`=0, `prog_addr`=0 and `prog_data`=0. The pending unlock step and the verify hold are also cleared.
- R2: All outputs are registered and follow the inputs sampled at the previous clock edge. Outside verify, and with `oe_hv` low, `mode` is encoded as follows: strobe high with `oe_n` high gives 1 (standby); strobe high with `oe_n` low gives 2 (address latch); strobe low with `oe_n` low gives 0 (read); strobe low with `oe_n` high gives 3 (output off).
- R3: Outside verify, with the strobe low, `oe_n` low, `oe_hv` low and `a9_hv` high, `mode` is 4 (identifier). `id_byte` is then 0xDA when `addr[8]` is 0 and 0x1F when `addr[8]` is 1. In every other case `id_byte` is 0.
- R4: `drive_en` is 1 exactly when the strobe was low, `oe_n` low and `oe_hv` low at the previous edge. This holds in every mode, so standby never drives the bus.
- R5: A program is an `oe_hv` write whose strobe falls and which is neither a direct erase nor an expected unlock command. The edge that samples the strobe low produces a one-cycle `prog_pulse`, loads `prog_addr`/`prog_data` from `addr`/`din`, and sets `mode` to 7 (program verify). Program has no minimum width.
- R6: A direct erase is a falling strobe with `oe_hv` and `a9_hv` high, `addr[10]`=1, `addr[8]`=0 and `addr[11]`=0. It produces a one-cycle `erase_pulse` and sets `mode` to 6 (erase verify), with no width requirement.
- R7: Two `oe_hv` writes in a row form the unlock sequence: 0xAA to 0x5555 with at least SHORT_US ticks high, then 0x10 to 0x2AAA with at least LONG_US ticks high. They produce one `erase_pulse` at the fall of the second write and no `prog_pulse`. A tick is counted at each clock edge where the strobe is high and was already high at the edge before.
- R8: An expected unlock write that is held for too few ticks neither advances the sequence nor programs. It returns the sequence to its start.
- R9: Any `oe_hv` write that is not the expected next command is treated as a program and returns the unlock sequence to its start.
- R10: While the strobe stays low, no `erase_pulse` or `prog_pulse` occurs and the mode does not leave the normal modes, whatever `oe_hv`, `a9_hv`, `addr` and `din` do.
- R11: Once in mode 6 or 7, `mode` stays 6 or 7 until reset, whatever the bus does. A later erase switches it to 6 and a later program switches it to 7.
- R12: Outside verify, the strobe high together with `oe_hv` gives `mode` 5 (write pending). With `oe_hv` and the strobe low, `mode` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| strobe | input | 1 | Address strobe, high active |
| oe_n | input | 1 | Output enable, low active |
| oe_hv | input | 1 | Programming voltage present on the output-enable pin |
| a9_hv | input | 1 | Elevated voltage present on address line 9 |
| addr | input | AW (16) | Full byte address |
| din | input | DW (8) | Write data |
| mode | output | 3 | Encoded current mode |
| drive_en | output | 1 | Enable for the data output drivers |
| id_byte | output | DW (8) | Identifier byte, zero when not in identifier mode |
| erase_pulse | output | 1 | One-cycle array erase strobe |
| prog_pulse | output | 1 | One-cycle array program strobe |
| prog_addr | output | AW (16) | Address of the last program |
| prog_data | output | DW (8) | Data of the last program |

## Verification
The hardest case to reach is the unlock sequence under timing stress. A correctly timed first write has to be followed by a second write that is either correct but held too briefly, or correct after an interrupting write. Each of these must be told apart from a real erase. The bench scales LONG_US down to 200 and gives a tick every second clock. Its write task holds the strobe for a chosen number of cycles, which places pulses just above and just below each threshold. The behavioural reference model steps alongside the design on every clock, and separate pulse counters confirm the expected number of erase and program strobes for each scenario.

// File: rtl/mode_seq_pkg.sv
// Shared mode encoding for the erase/program mode sequencer.
// Assumes a 3-bit mode bus read by neighbouring array control logic.
package mode_seq_pkg;
    typedef enum logic [2:0] {
        MD_READ      = 3'd0,
        MD_STANDBY   = 3'd1,
        MD_LATCH     = 3'd2,
        MD_OUTOFF    = 3'd3,
        MD_IDENT     = 3'd4,
        MD_WRITE     = 3'd5,
        MD_ERASE_VFY = 3'd6,
        MD_PROG_VFY  = 3'd7
    } dev_mode_t;
endpackage

// File: rtl/strobe_timer.sv
// Strobe edge detector and high-time counter.
// Counts microsecond ticks while the strobe stays high. The count
// restarts on a rising edge and saturates at MAX_US. The width is
// stable when the fall is flagged, and the consumer reads it there.
module strobe_timer #(
    parameter int MAX_US = 100000,
    localparam int CW = $clog2(MAX_US + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          us_tick,
    output logic          fall,
    output logic [CW-1:0] width
);
    localparam logic [CW-1:0] SAT = CW'(MAX_US);

    logic          strobe_q;
    logic [CW-1:0] cnt_q;
    logic          rise;

    assign rise  = strobe && !strobe_q;
    assign fall  = !strobe && strobe_q;
    assign width = cnt_q;

    // Previous strobe sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // Tick counter over the current high phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cnt_q <= '0;
        else if (rise)                             cnt_q <= '0;
        else if (strobe && us_tick && cnt_q < SAT) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/unlock_seq.sv
// Two-step unlock tracker for the command route to erase.
// Each write is offered as wr_fire with its address, data and width.
// A write that matches the expected next command is absorbed (it is
// not programmed); it advances only if it was held long enough.
// Any other write, or a short one, returns the tracker to the start.
module unlock_seq #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 17,
    parameter int SHORT_US = 50,
    parameter int LONG_US = 100000,
    parameter logic [AW-1:0] STEP1_ADDR = 16'h5555,
    parameter logic [DW-1:0] STEP1_DATA = 8'hAA,
    parameter logic [AW-1:0] STEP2_ADDR = 16'h2AAA,
    parameter logic [DW-1:0] STEP2_DATA = 8'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  logic          clear,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] width,
    output logic          absorb,
    output logic          cmd_erase
);
    localparam logic [CW-1:0] SHORT_W = CW'(SHORT_US);
    localparam logic [CW-1:0] LONG_W  = CW'(LONG_US);

    logic armed_q;
    logic want1, want2, ok1, ok2;

    // Match the write against the step currently expected.
    always_comb begin
        want1     = !armed_q && (addr == STEP1_ADDR) && (data == STEP1_DATA);
        want2     =  armed_q && (addr == STEP2_ADDR) && (data == STEP2_DATA);
        ok1       = want1 && (width >= SHORT_W);
        ok2       = want2 && (width >= LONG_W);
        absorb    = wr_fire && (want1 || want2);
        cmd_erase = wr_fire && ok2;
    end

    // Step state: armed only after a good first command.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (clear)   armed_q <= 1'b0;
        else if (wr_fire) armed_q <= ok1;
    end
endmodule

// File: rtl/mode_decode.sv
// Combinational decode of the pin-level mode, before verify hold.
// Assumes oe_hv dominates oe_n, since the pin is then far above logic high.
module mode_decode
    import mode_seq_pkg::*;
(
    input  logic      strobe,
    input  logic      oe_n,
    input  logic      oe_hv,
    input  logic      a9_hv,
    output dev_mode_t base
);
    // Priority: high voltage, strobe, output enable, identifier.
    always_comb begin
        if (oe_hv)       base = strobe ? MD_WRITE : MD_OUTOFF;
        else if (strobe) base = oe_n ? MD_STANDBY : MD_LATCH;
        else if (!oe_n)  base = a9_hv ? MD_IDENT : MD_READ;
        else             base = MD_OUTOFF;
    end
endmodule

// File: rtl/mode_seq.sv
// Top of the erase/program mode sequencer.
// Operations are decided on the strobe's falling edge. Outputs are
// registered, so they appear one clock after the deciding sample.
// A completed erase or program holds a verify mode until rst_n.
// Assumes AW >= 12, because address bits 8, 10 and 11 select direct erase.
module mode_seq
    import mode_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SHORT_US = 50,
    parameter int LONG_US = 100000,
    parameter logic [DW-1:0] ID_MAKER = 8'hDA,
    parameter logic [DW-1:0] ID_PART  = 8'h1F,
    localparam int CW = $clog2(LONG_US + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          us_tick,
    input  logic          strobe,
    input  logic          oe_n,
    input  logic          oe_hv,
    input  logic          a9_hv,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [2:0]    mode,
    output logic          drive_en,
    output logic [DW-1:0] id_byte,
    output logic          erase_pulse,
    output logic          prog_pulse,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data
);
    logic          fall;
    logic [CW-1:0] width;
    logic          direct_erase, wr_fire, absorb, cmd_erase;
    logic          do_erase, do_prog;
    dev_mode_t     base;
    dev_mode_t     mode_q, vfy_q;
    logic          hold_q;

    strobe_timer #(.MAX_US(LONG_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .us_tick(us_tick),
        .fall(fall), .width(width)
    );

    unlock_seq #(
        .AW(AW), .DW(DW), .CW(CW), .SHORT_US(SHORT_US), .LONG_US(LONG_US)
    ) u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .clear(direct_erase),
        .addr(addr), .data(din), .width(width),
        .absorb(absorb), .cmd_erase(cmd_erase)
    );

    mode_decode u_dec (
        .strobe(strobe), .oe_n(oe_n), .oe_hv(oe_hv), .a9_hv(a9_hv), .base(base)
    );

    // Classify the operation launched by this strobe fall.
    always_comb begin
        direct_erase = fall && oe_hv && a9_hv && addr[10] && !addr[11] && !addr[8];
        wr_fire      = fall && oe_hv && !direct_erase;
        do_erase     = direct_erase || cmd_erase;
        do_prog      = wr_fire && !absorb;
    end

    // Verify hold: set by any operation, left only through reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            vfy_q  <= MD_ERASE_VFY;
        end else if (do_erase) begin
            hold_q <= 1'b1;
            vfy_q  <= MD_ERASE_VFY;
        end else if (do_prog) begin
            hold_q <= 1'b1;
            vfy_q  <= MD_PROG_VFY;
        end
    end

    // Registered mode report.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= MD_STANDBY;
        else if (do_erase) mode_q <= MD_ERASE_VFY;
        else if (do_prog)  mode_q <= MD_PROG_VFY;
        else if (hold_q)   mode_q <= vfy_q;
        else               mode_q <= base;
    end

    // Output driver enable and identifier byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_en <= 1'b0;
            id_byte  <= '0;
        end else begin
            drive_en <= !strobe && !oe_n && !oe_hv;
            if (!hold_q && base == MD_IDENT) id_byte <= addr[8] ? ID_PART : ID_MAKER;
            else                             id_byte <= '0;
        end
    end

    // Array strobes and the captured program target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_pulse <= 1'b0;
            prog_pulse  <= 1'b0;
            prog_addr   <= '0;
            prog_data   <= '0;
        end else begin
            erase_pulse <= do_erase;
            prog_pulse  <= do_prog;
            if (do_prog) begin
                prog_addr <= addr;
                prog_data <= din;
            end
        end
    end

    assign mode = mode_q;
endmodule

// File: rtl/mode_seq_chk.sv
// Temporal checks for mode_seq, bound to every instance of it.
module mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strobe,
    input logic [2:0] mode,
    input logic       drive_en,
    input logic       erase_pulse,
    input logic       prog_pulse
);
    // R5: program strobe lasts one cycle and lands in program verify
    a_r5_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |=> !prog_pulse);
    a_r5_prog_vfy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_pulse |-> mode == 3'd7);
    // R6: erase strobe lands in erase verify
    a_r6_erase_vfy: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |-> mode == 3'd6);
    // R10: array strobes follow a strobe fall only
    a_r10_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_pulse || prog_pulse) |-> (!$past(strobe) && $past(strobe, 2)));
    // R11: verify is held
    a_r11_vfy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 || mode == 3'd7) |=> (mode == 3'd6 || mode == 3'd7));
    // R4: standby never drives
    a_r4_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |-> !drive_en);
    // R7: a single fall never triggers both strobes
    a_r7_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_pulse && prog_pulse));
endmodule

bind mode_seq mode_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .mode(mode),
    .drive_en(drive_en), .erase_pulse(erase_pulse), .prog_pulse(prog_pulse)
);

// File: tb/mode_seq_tb_top.sv
// Bench for mode_seq: a behavioural reference model compared every clock,
// plus pulse counters checked per scenario.
module mode_seq_tb_top;
    localparam int SHORT = 50;
    localparam int LONG  = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        strobe = 1'b0, oe_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [2:0]  mode;
    logic        drive_en, erase_pulse, prog_pulse;
    logic [7:0]  id_byte, prog_data;
    logic [15:0] prog_addr;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    int    seen_erase = 0, seen_prog = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    mode_seq #(.SHORT_US(SHORT), .LONG_US(LONG)) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .strobe(strobe),
        .oe_n(oe_n), .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
        .mode(mode), .drive_en(drive_en), .id_byte(id_byte),
        .erase_pulse(erase_pulse), .prog_pulse(prog_pulse),
        .prog_addr(prog_addr), .prog_data(prog_data)
    );

    always #4 clk = ~clk;

    // Reference model state
    int   m_w = 0, m_vfy = 0;
    bit   m_prev = 0, m_armed = 0;
    int   e_mode = 1, e_id = 0, e_ep = 0, e_pp = 0, e_drv = 0, e_pa = 0, e_pd = 0;

    always @(posedge clk) begin
        int base;
        bit ep, pp;
        if (!rst_n) begin
            m_w = 0; m_vfy = 0; m_prev = 0; m_armed = 0;
            e_mode = 1; e_id = 0; e_ep = 0; e_pp = 0; e_drv = 0; e_pa = 0; e_pd = 0;
        end else begin
            if (oe_hv)       base = strobe ? 5 : 3;
            else if (strobe) base = oe_n ? 1 : 2;
            else if (!oe_n)  base = a9_hv ? 4 : 0;
            else             base = 3;
            ep = 0; pp = 0;
            if (!strobe && m_prev && oe_hv) begin
                if (a9_hv && addr[10] && !addr[11] && !addr[8]) begin
                    ep = 1; m_armed = 0;
                end else if (!m_armed && addr == 16'h5555 && din == 8'hAA) begin
                    m_armed = (m_w >= SHORT);
                end else if (m_armed && addr == 16'h2AAA && din == 8'h10) begin
                    ep = (m_w >= LONG); m_armed = 0;
                end else begin
                    pp = 1; m_armed = 0; e_pa = addr; e_pd = din;
                end
            end
            e_id  = (m_vfy == 0 && base == 4) ? (addr[8] ? 8'h1F : 8'hDA) : 0;
            e_drv = (!strobe && !oe_n && !oe_hv);
            if (ep) m_vfy = 6; else if (pp) m_vfy = 7;
            e_mode = (m_vfy != 0) ? m_vfy : base;
            e_ep = ep; e_pp = pp;
            if (strobe && !m_prev)                     m_w = 0;
            else if (strobe && us_tick && m_w < LONG)  m_w++;
            m_prev = strobe;
        end
    end

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            n_cmp++;
            if (int'(mode) != e_mode || int'(id_byte) != e_id || int'(erase_pulse) != e_ep ||
                int'(prog_pulse) != e_pp || int'(drive_en) != e_drv ||
                int'(prog_addr) != e_pa || int'(prog_data) != e_pd) begin
                n_bad++;
                $display("FAIL %s cyc %0d: act mode=%0d id=%h ep=%b pp=%b drv=%b pa=%h pd=%h exp mode=%0d id=%h ep=%0d pp=%0d drv=%0d pa=%h pd=%h",
                    cur_req, cyc, mode, id_byte, erase_pulse, prog_pulse, drive_en, prog_addr,
                    prog_data, e_mode, e_id, e_ep, e_pp, e_drv, e_pa, e_pd);
            end
            if (erase_pulse) seen_erase++;
            if (prog_pulse)  seen_prog++;
        end
    end

    // Watchdog and cycle count
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Microsecond tick every second clock
    initial begin
        forever begin
            @(negedge clk); us_tick = ~us_tick;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; strobe = 0; oe_n = 1; oe_hv = 0; a9_hv = 0; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        seen_erase = 0; seen_prog = 0;
    endtask

    task automatic bus(input bit s, input bit oen, input bit hv, input bit a9, input logic [15:0] a);
        @(negedge clk);
        strobe = s; oe_n = oen; oe_hv = hv; a9_hv = a9; addr = a;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit a9, input int hi);
        @(negedge clk);
        addr = a; din = d; oe_n = 1; oe_hv = 1; a9_hv = a9; strobe = 1;
        repeat (hi) @(negedge clk);
        strobe = 0;
        repeat (3) @(negedge clk);
        oe_hv = 0; a9_hv = 0;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1: reset values (still in reset above; sample one cycle after release)
        cur_req = "R1";
        check("R1 mode", int'(mode), 1);
        check("R1 drive_en", int'(drive_en), 0);
        check("R1 pulses", int'(erase_pulse) + int'(prog_pulse), 0);
        cmp_on = 1;

        cur_req = "R2";   // normal pin modes
        bus(1, 1, 0, 0, 16'h0000);
        check("R2 standby", int'(mode), 1);
        bus(1, 0, 0, 0, 16'h0000);
        check("R2 latch", int'(mode), 2);
        bus(0, 0, 0, 0, 16'h0123);
        check("R2 read", int'(mode), 0);
        cur_req = "R4";
        check("R4 drive", int'(drive_en), 1);
        bus(0, 1, 0, 0, 16'h0000);
        check("R2 outoff", int'(mode), 3);

        cur_req = "R3";   // identifier bytes
        bus(0, 0, 0, 1, 16'h0000);
        check("R3 maker", int'(id_byte), 8'hDA);
        bus(0, 0, 0, 1, 16'h0100);
        check("R3 part", int'(id_byte), 8'h1F);
        bus(0, 1, 0, 0, 16'h0000);

        cur_req = "R12";  // write pending while strobe high with oe_hv
        @(negedge clk); oe_hv = 1; strobe = 1; addr = 16'h1234; din = 8'h5A;
        repeat (2) @(negedge clk);
        check("R12 write", int'(mode), 5);
        cur_req = "R5";
        strobe = 0;
        @(negedge clk);
        check("R5 pulse", int'(prog_pulse), 1);
        check("R5 addr", int'(prog_addr), 16'h1234);
        check("R5 data", int'(prog_data), 8'h5A);
        repeat (2) @(negedge clk); oe_hv = 0;
        cur_req = "R11";  // verify hold across pin modes, then switch
        bus(1, 1, 0, 0, 16'h0000);
        bus(0, 0, 0, 1, 16'h0000);
        check("R11 prog vfy held", int'(mode), 7);
        cur_req = "R6";
        wr(16'h0400, 8'h00, 1, 3);
        check("R6 erase count", seen_erase, 1);
        check("R11 erase vfy", int'(mode), 6);

        do_reset();
        cur_req = "R10";  // inhibit with strobe low
        @(negedge clk); oe_hv = 1; a9_hv = 1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); addr = (i[0]) ? 16'h5555 : 16'h0400; din = 8'hAA;
        end
        oe_hv = 0; a9_hv = 0;
        repeat (2) @(negedge clk);
        check("R10 no pulse", seen_erase + seen_prog, 0);
        check("R10 normal", int'(mode), 3);

        cur_req = "R7";   // good unlock sequence
        wr(16'h5555, 8'hAA, 0, 110);
        wr(16'h2AAA, 8'h10, 0, 420);
        check("R7 erase", seen_erase, 1);
        check("R7 no prog", seen_prog, 0);
        check("R7 mode", int'(mode), 6);

        do_reset();
        cur_req = "R8";   // short first step: no advance
        wr(16'h5555, 8'hAA, 0, 60);
        check("R8 absorbed", seen_prog, 0);
        check("R8 mode", int'(mode), 3);
        wr(16'h2AAA, 8'h10, 0, 420);
        check("R8 no erase", seen_erase, 0);
        check("R8 prog", seen_prog, 1);

        do_reset();
        cur_req = "R8";   // short second step
        wr(16'h5555, 8'hAA, 0, 110);
        wr(16'h2AAA, 8'h10, 0, 300);
        check("R8 short2 nothing", seen_erase + seen_prog, 0);
        wr(16'h2AAA, 8'h10, 0, 420);
        check("R8 restart needed", seen_erase, 0);

        do_reset();
        cur_req = "R9";   // interrupting write resets the sequence
        wr(16'h5555, 8'hAA, 0, 110);
        wr(16'h2AAA, 8'h11, 0, 20);
        check("R9 prog", seen_prog, 1);
        wr(16'h2AAA, 8'h10, 0, 420);
        check("R9 no erase", seen_erase, 0);
        check("R9 prog again", seen_prog, 2);
        check("R9 mode", int'(mode), 7);

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule